// File: doc/BRIEF.md
# Three-Input Truth-Table Logic Unit

This block evaluates an arbitrary three-input Boolean function across three wide source vectors, one bit position at a time. The function is given as an 8-bit truth table: for every bit position the three source bits form an index, with the bit of `src_a` as the most significant index bit and the bit of `src_c` as the least significant, and the table bit at that index becomes the result bit. Any of the 256 functions of three inputs can be selected this way, including constants, plain copies, parity and bitwise blends.

The result can be write-masked per element. The element size, 32 or 64 bits, only decides which mask bit covers which bit of the result. An element whose mask bit is clear either keeps the prior destination value (merge), for which `src_a` stands in, or is cleared to zero (zero fill). With masking off, every element is written and the element size has no effect.

One request is accepted per cycle when `in_valid` is high. The result is registered and appears one clock later together with `out_valid`; between requests the result register holds its last value.

Top module: `ternlog_unit`

## Requirements
- R1: Result bit j equals `tt_imm[{src_a[j], src_b[j], src_c[j]}]` (src_a bit weight 4, src_b weight 2, src_c weight 1) for every written element.
- R2: Each result bit depends only on the three source bits at the same position; changing source bits elsewhere does not change it.
- R3: Table value 8'h00 yields all zeros, 8'hFF yields all ones and 8'hF0 returns `src_a` unchanged when masking is off.
- R4: Table value 8'hD8 gives a bitwise blend: the bit of `src_b` where `src_c` is 1, otherwise the bit of `src_a`.
- R5: With `mask_en` low, `wide_lanes` has no effect on the result and `lane_mask` is ignored.
- R6: With `wide_lanes` low (32-bit elements), `lane_mask[i]` controls result bits [32i+31:32i].
- R7: With `wide_lanes` high (64-bit elements), `lane_mask[i]` controls result bits [64i+63:64i] for i below DATA_W/64; the upper mask bits are ignored.
- R8: With `mask_en` high and `zero_fill` low, a masked-off element takes the value of `src_a`.
- R9: With `mask_en` high and `zero_fill` high, a masked-off element is all zeros.
- R10: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and the result for that request is present then.
- R11: After reset `out_valid` is 0 and `result` is all zeros.
- R12: While `in_valid` is low, `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| src_a | input | DATA_W | First source, most significant table index bit; prior value under merge |
| src_b | input | DATA_W | Second source, middle table index bit |
| src_c | input | DATA_W | Third source, least significant table index bit |
| tt_imm | input | 8 | Truth table of the function |
| lane_mask | input | DATA_W/32 | Per-element write mask, bit 0 for the lowest element |
| wide_lanes | input | 1 | 0: 32-bit elements, 1: 64-bit elements |
| zero_fill | input | 1 | 0: merge masked-off elements, 1: clear them |
| mask_en | input | 1 | Apply lane_mask |
| out_valid | output | 1 | Result of the previous cycle's request is present |
| result | output | DATA_W | Registered result |

## Verification
Every result is due exactly one clock after the cycle in which its request is presented, so the bench drives a request on a falling edge and compares `out_valid` and `result` on the following falling edge, after the single register stage has captured it. Idle cycles are checked the same way: the model keeps its previous expected vector and the design must show it unchanged with `out_valid` low. The reference model recomputes every bit from the table with integer loops and maps bits to mask bits by division by the element size, so it shares no structure with the design.

// File: rtl/tl_pkg.sv
package tl_pkg;

  // Width of one table index (three operand bits).
  localparam int unsigned TT_IDX_W = 3;
  localparam int unsigned TT_W     = 1 << TT_IDX_W;

  // Smallest and largest element sizes for masking.
  localparam int unsigned NARROW_BITS = 32;
  localparam int unsigned WIDE_BITS   = 64;

  typedef enum logic {
    FILL_MERGE = 1'b0,
    FILL_ZERO  = 1'b1
  } fill_mode_e;

  typedef enum logic {
    ELEM_NARROW = 1'b0,
    ELEM_WIDE   = 1'b1
  } elem_size_e;

  // Truth-table lookup for one bit position.
  function automatic logic tt_pick(input logic [TT_W-1:0] table_bits,
                                   input logic a_bit,
                                   input logic b_bit,
                                   input logic c_bit);
    logic [TT_IDX_W-1:0] idx;
    idx = {a_bit, b_bit, c_bit};
    return table_bits[idx];
  endfunction

  // Final value of one bit given whether its element is written.
  function automatic logic fill_bit(input logic written,
                                    input logic func_bit,
                                    input logic prior_bit,
                                    input fill_mode_e mode);
    logic v;
    if (written)               v = func_bit;
    else if (mode == FILL_ZERO) v = 1'b0;
    else                       v = prior_bit;
    return v;
  endfunction

endpackage

// File: rtl/tl_bit_eval.sv
module tl_bit_eval
  import tl_pkg::*;
#(
  parameter int unsigned DATA_W = 512
) (
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] src_c,
  input  logic [TT_W-1:0]   tt_imm,
  output logic [DATA_W-1:0] func_out
);

  // One independent table lookup per bit position.
  for (genvar j = 0; j < DATA_W; j++) begin : g_bit
    assign func_out[j] = tt_pick(tt_imm, src_a[j], src_b[j], src_c[j]);
  end

endmodule

// File: rtl/tl_lane_enable.sv
module tl_lane_enable
  import tl_pkg::*;
#(
  parameter int unsigned DATA_W = 512,
  localparam int unsigned N_NARROW = DATA_W / NARROW_BITS,
  localparam int unsigned MASK_W   = N_NARROW
) (
  input  logic [MASK_W-1:0] lane_mask,
  input  elem_size_e        elem_size,
  input  logic              mask_en,
  output logic [N_NARROW-1:0] narrow_keep,
  output logic [DATA_W-1:0]   bit_keep
);

  localparam int unsigned NARROW_PER_WIDE = WIDE_BITS / NARROW_BITS;

  // Per 32-bit slice: pick the mask bit that owns it in either element size.
  for (genvar k = 0; k < N_NARROW; k++) begin : g_slice
    logic sel_narrow;
    logic sel_wide;
    logic slice_on;
    assign sel_narrow = lane_mask[k];
    assign sel_wide   = lane_mask[k / NARROW_PER_WIDE];
    assign slice_on   = (elem_size == ELEM_WIDE) ? sel_wide : sel_narrow;
    assign narrow_keep[k] = !mask_en || slice_on;
    assign bit_keep[k*NARROW_BITS +: NARROW_BITS] = {NARROW_BITS{narrow_keep[k]}};
  end

endmodule

// File: rtl/tl_fill.sv
module tl_fill
  import tl_pkg::*;
#(
  parameter int unsigned DATA_W = 512
) (
  input  logic [DATA_W-1:0] func_in,
  input  logic [DATA_W-1:0] prior,
  input  logic [DATA_W-1:0] bit_keep,
  input  fill_mode_e        mode,
  output logic [DATA_W-1:0] fill_out
);

  for (genvar j = 0; j < DATA_W; j++) begin : g_bit
    assign fill_out[j] = fill_bit(bit_keep[j], func_in[j], prior[j], mode);
  end

endmodule

// File: rtl/ternlog_unit.sv
module ternlog_unit
  import tl_pkg::*;
#(
  parameter int unsigned DATA_W = 512,
  localparam int unsigned MASK_W = DATA_W / NARROW_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] src_c,
  input  logic [7:0]        tt_imm,
  input  logic [MASK_W-1:0] lane_mask,
  input  logic              wide_lanes,
  input  logic              zero_fill,
  input  logic              mask_en,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);

  // Named internal events, visible to the bound checker.
  logic [DATA_W-1:0] func_vec;
  logic [DATA_W-1:0] bit_keep;
  logic [MASK_W-1:0] slice_keep;
  logic [DATA_W-1:0] next_result;
  logic              capture;
  elem_size_e        elem_size;
  fill_mode_e        fill_mode;

  assign elem_size = elem_size_e'(wide_lanes);
  assign fill_mode = fill_mode_e'(zero_fill);
  assign capture   = in_valid;

  tl_bit_eval #(.DATA_W(DATA_W)) u_eval (
    .src_a    (src_a),
    .src_b    (src_b),
    .src_c    (src_c),
    .tt_imm   (tt_imm),
    .func_out (func_vec)
  );

  tl_lane_enable #(.DATA_W(DATA_W)) u_enable (
    .lane_mask   (lane_mask),
    .elem_size   (elem_size),
    .mask_en     (mask_en),
    .narrow_keep (slice_keep),
    .bit_keep    (bit_keep)
  );

  tl_fill #(.DATA_W(DATA_W)) u_fill (
    .func_in  (func_vec),
    .prior    (src_a),
    .bit_keep (bit_keep),
    .mode     (fill_mode),
    .fill_out (next_result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= capture;
      if (capture) result <= next_result;
    end
  end

endmodule

module ternlog_unit_checker #(
  parameter int unsigned DATA_W = 512,
  localparam int unsigned MASK_W = DATA_W / 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] src_a,
  input logic [7:0]        tt_imm,
  input logic [MASK_W-1:0] lane_mask,
  input logic              zero_fill,
  input logic              mask_en,
  input logic [MASK_W-1:0] slice_keep,
  input logic              out_valid,
  input logic [DATA_W-1:0] result
);

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R10
  AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result)); // R12
  AST_CONST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mask_en && tt_imm == 8'h00) |=> (result == '0)); // R3
  AST_CONST_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mask_en && tt_imm == 8'hFF) |=> (result == '1)); // R3
  AST_PASS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mask_en && tt_imm == 8'hF0) |=> (result == $past(src_a))); // R3
  AST_MERGE_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mask_en && !zero_fill && lane_mask == '0) |=> (result == $past(src_a))); // R8
  AST_ZERO_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mask_en && zero_fill && lane_mask == '0) |=> (result == '0)); // R9
  AST_UNMASKED_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_en |-> (slice_keep == '1)); // R5

endmodule

bind ternlog_unit ternlog_unit_checker #(.DATA_W(DATA_W)) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .src_a      (src_a),
  .tt_imm     (tt_imm),
  .lane_mask  (lane_mask),
  .zero_fill  (zero_fill),
  .mask_en    (mask_en),
  .slice_keep (slice_keep),
  .out_valid  (out_valid),
  .result     (result)
);

// File: tb/ternlog_unit_bench.sv
module ternlog_unit_bench;

  localparam int W  = 512;
  localparam int MW = W / 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [W-1:0]  src_a = '0, src_b = '0, src_c = '0;
  logic [7:0]    tt_imm = 8'h00;
  logic [MW-1:0] lane_mask = '0;
  logic          wide_lanes = 1'b0, zero_fill = 1'b0, mask_en = 1'b0;
  logic          out_valid;
  logic [W-1:0]  result;

  int n_run = 0;
  int n_fail = 0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] exp_hold = '0;

  always #2.5 clk = ~clk;

  ternlog_unit #(.DATA_W(W)) u_ternlog_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .src_a(src_a), .src_b(src_b), .src_c(src_c), .tt_imm(tt_imm),
    .lane_mask(lane_mask), .wide_lanes(wide_lanes), .zero_fill(zero_fill),
    .mask_en(mask_en), .out_valid(out_valid), .result(result)
  );

  function automatic logic [W-1:0] rnd_vec();
    logic [W-1:0] v;
    for (int i = 0; i < W / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  // Behavioural model: bit by bit, element found by division.
  function automatic logic [W-1:0] model(input logic [W-1:0] a, b, c,
                                         input logic [7:0] imm,
                                         input logic [MW-1:0] m,
                                         input logic wide, zf, men);
    logic [W-1:0] r;
    for (int j = 0; j < W; j++) begin
      int idx, elem;
      logic on;
      idx  = (a[j] ? 4 : 0) + (b[j] ? 2 : 0) + (c[j] ? 1 : 0);
      elem = wide ? j / 64 : j / 32;
      on   = !men || m[elem];
      if (on)      r[j] = imm[idx];
      else if (zf) r[j] = 1'b0;
      else         r[j] = a[j];
    end
    return r;
  endfunction

  task automatic check_vec(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s result act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s out_valid act=%b exp=%b", req, act, exp);
    end
  endtask

  // Drive one cycle on a falling edge, compare on the next falling edge.
  task automatic step(input string req, input logic v,
                      input logic [W-1:0] a, b, c, input logic [7:0] imm,
                      input logic [MW-1:0] m, input logic wide, zf, men);
    in_valid = v; src_a = a; src_b = b; src_c = c; tt_imm = imm;
    lane_mask = m; wide_lanes = wide; zero_fill = zf; mask_en = men;
    if (v) exp_hold = model(a, b, c, imm, m, wide, zf, men);
    exp_q.push_back(exp_hold);
    @(posedge clk);
    @(negedge clk);
    check_bit(req, out_valid, v);
    check_vec(req, result, exp_q.pop_front());
  endtask

  task automatic go(input string req, input logic [W-1:0] a, b, c,
                    input logic [7:0] imm, input logic [MW-1:0] m,
                    input logic wide, zf, men);
    step(req, 1'b1, a, b, c, imm, m, wide, zf, men);
  endtask

  bit done = 0;

  initial begin
    logic [W-1:0] a, b, c, r1, r2;
    @(negedge clk);
    // R11: reset state
    check_bit("R11", out_valid, 1'b0);
    check_vec("R11", result, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    a = rnd_vec(); b = rnd_vec(); c = rnd_vec();
    // R3: constants and pass-through
    go("R3", a, b, c, 8'h00, '0, 1'b0, 1'b0, 1'b0);
    go("R3", a, b, c, 8'hFF, '0, 1'b0, 1'b0, 1'b0);
    go("R3", a, b, c, 8'hF0, '0, 1'b0, 1'b0, 1'b0);
    // R4: blend, expected written directly
    go("R4", a, b, c, 8'hD8, '0, 1'b0, 1'b0, 1'b0);
    check_vec("R4", result, (b & c) | (a & ~c));
    // R1: several tables over random data, including xor3 and majority
    foreach (r1[i]) ;
    go("R1", a, b, c, 8'h96, '0, 1'b0, 1'b0, 1'b0);
    check_vec("R1", result, a ^ b ^ c);
    go("R1", a, b, c, 8'hE8, '0, 1'b0, 1'b0, 1'b0);
    check_vec("R1", result, (a & b) | (a & c) | (b & c));
    for (int t = 0; t < 20; t++)
      go("R1", rnd_vec(), rnd_vec(), rnd_vec(), 8'($urandom), '0, 1'b0, 1'b0, 1'b0);
    // R1: walk all eight index patterns at bit 0
    for (int k = 0; k < 8; k++)
      go("R1", W'(k >> 2), W'((k >> 1) & 1), W'(k & 1), 8'(1 << k), '0, 1'b0, 1'b0, 1'b0);
    // R2: flipping bit 100 only changes bit 100
    go("R2", a, b, c, 8'h96, '0, 1'b0, 1'b0, 1'b0);
    r1 = result;
    a[100] = ~a[100];
    go("R2", a, b, c, 8'h96, '0, 1'b0, 1'b0, 1'b0);
    r2 = result;
    n_run++;
    if ((r1 ^ r2) !== (W'(1) << 100)) begin
      n_fail++;
      $display("FAIL R2 diff act=%h exp=%h", r1 ^ r2, W'(1) << 100);
    end
    // R5: masking off, element size and mask ignored
    go("R5", a, b, c, 8'h6A, 16'h1234, 1'b0, 1'b1, 1'b0);
    r1 = result;
    go("R5", a, b, c, 8'h6A, 16'hBEEF, 1'b1, 1'b0, 1'b0);
    check_vec("R5", result, r1);
    // R6: 32-bit elements, single and mixed masks, merge and zero
    go("R6", a, b, c, 8'hFF, 16'h0001, 1'b0, 1'b1, 1'b1);
    check_vec("R6", result, W'(32'hFFFF_FFFF));
    go("R6", a, b, c, 8'h3C, 16'hA5C3, 1'b0, 1'b0, 1'b1);
    go("R6", a, b, c, 8'h3C, 16'h5A3C, 1'b0, 1'b1, 1'b1);
    // R7: 64-bit elements, upper mask bits ignored
    go("R7", a, b, c, 8'hFF, 16'hFF01, 1'b1, 1'b1, 1'b1);
    check_vec("R7", result, W'(64'hFFFF_FFFF_FFFF_FFFF));
    go("R7", a, b, c, 8'hA1, 16'h0096, 1'b1, 1'b0, 1'b1);
    go("R7", a, b, c, 8'hA1, 16'hFF69, 1'b1, 1'b1, 1'b1);
    // R8 / R9: all masked off
    go("R8", a, b, c, 8'hFF, '0, 1'b0, 1'b0, 1'b1);
    check_vec("R8", result, a);
    go("R9", a, b, c, 8'hFF, '0, 1'b1, 1'b1, 1'b1);
    check_vec("R9", result, '0);
    // R10 / R12: idle cycles hold, back-to-back requests
    go("R10", a, b, c, 8'h96, '0, 1'b0, 1'b0, 1'b0);
    for (int t = 0; t < 3; t++)
      step("R12", 1'b0, rnd_vec(), rnd_vec(), rnd_vec(), 8'h00, '0, 1'b0, 1'b1, 1'b1);
    for (int t = 0; t < 30; t++)
      step("R10", t % 3 != 0, rnd_vec(), rnd_vec(), rnd_vec(), 8'($urandom),
           MW'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule